// File: doc/BRIEF.md
# Wide-Line Flash Fetch Buffer

This block sits between an instruction fetch port and a slow flash array. The flash answers a read with a 128-bit line after a fixed number of cycles. The block keeps the most recent line, together with its line address, in a single line register. It then serves 16-bit and 32-bit opcode fetches out of that register in the cycle they are requested. Flash is read only when a fetch falls outside the buffered line, so a run of sequential opcodes costs one slow read per line instead of one per opcode. Code executes straight from flash; nothing is copied into RAM first.

The CPU raises `fetch_req` with a byte address and a size, and holds them steady until `fetch_ready` or `fetch_err` is seen. On a hit, `fetch_ready` and the opcode appear combinationally in the same cycle. On a miss the block pulses a flash read, waits out the flash latency, loads the line and tag, and then answers as a hit. A misaligned fetch is refused at once. A flush input discards the buffered line and any refill in flight.

Top module: `fetch_line_buffer`

## Requirements
- R1: After reset the buffered line is invalid: with no request pending, `fetch_ready`, `fetch_err` and `flash_rd` are 0, and the first fetch always misses.
- R2: A fetch whose line address (`fetch_addr` above the in-line byte offset) equals the buffered tag, while no refill is running, raises `fetch_ready` in the same cycle and issues no flash read.
- R3: On a miss, `flash_rd` is high for exactly one cycle with `flash_addr` set to the line address. The flash data is taken FLASH_LAT cycles after that cycle, and `fetch_ready` rises in the cycle after that: FLASH_LAT+1 cycles after the read cycle.
- R4: A 32-bit fetch (`fetch_word`=1) returns the four bytes at offsets off..off+3 of the line, little-endian: line byte k sits in `flash_data[8k+7:8k]` and the byte at off becomes `fetch_opcode[7:0]`.
- R5: A 16-bit fetch (`fetch_word`=0) returns the two bytes at off and off+1 in `fetch_opcode[15:0]` and 0 in `fetch_opcode[31:16]`.
- R6: A 32-bit fetch whose address is not a multiple of 4, a 16-bit fetch at an odd address, or any fetch that would run past the end of the line, raises `fetch_err` in the same cycle. That fetch gets no `fetch_ready`, starts no flash read and leaves the buffered line unchanged.
- R7: A `flush` pulse invalidates the line, so the next fetch to the previously buffered line misses.
- R8: A `flush` during a refill abandons it: the returned data is discarded, and a still-pending fetch issues a new flash read once the block is idle.
- R9: A miss to another line replaces the buffered line, after which a fetch to the old line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate the line and cancel any refill |
| fetch_req | input | 1 | Fetch request, held until ready or error |
| fetch_addr | input | ADDR_W | Byte address of the opcode |
| fetch_word | input | 1 | 1 = 32-bit opcode, 0 = 16-bit opcode |
| fetch_ready | output | 1 | Opcode valid this cycle |
| fetch_err | output | 1 | Fetch refused as misaligned |
| fetch_opcode | output | 32 | Extracted opcode, upper half 0 for 16-bit |
| flash_rd | output | 1 | One-cycle flash line read request |
| flash_addr | output | ADDR_W-log2(LINE_W/8) | Line address of the read |
| flash_data | input | LINE_W | Line returned by flash FLASH_LAT cycles after the read |

## Verification
The bench builds the block with ADDR_W=12, LINE_W=128 and FLASH_LAT=3. The 8-bit tag then covers the highest line of the space, and the short latency lets exact ready timing be counted on every miss. The bench's flash model drives garbage on every cycle except the one FLASH_LAT cycles after a read, so a refill that captures too early or too late returns a wrong opcode. Flushes are placed both in idle cycles and in the middle of a refill, to exercise the cancel path and the reissued read.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_WAIT = 1'b1
  } refill_state_e;

  // Byte count of one fetch for the given size select.
  function automatic int unsigned fetch_bytes(input logic is_word);
    return is_word ? 4 : 2;
  endfunction

  // A fetch is refused when it is not aligned to its own size
  // or when its last byte lies beyond the line.
  function automatic logic fetch_bad(input int unsigned off,
                                     input logic        is_word,
                                     input int unsigned line_bytes);
    int unsigned nb;
    nb = fetch_bytes(is_word);
    return ((off % nb) != 0) || ((off + nb) > line_bytes);
  endfunction

endpackage

// File: rtl/fb_line_store.sv
module fb_line_store #(
  parameter int LINE_W = 128,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [LINE_W-1:0] load_data,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      tag   <= load_tag;
      data  <= load_data;
    end
  end

endmodule

// File: rtl/fb_refill_ctrl.sv
module fb_refill_ctrl #(
  parameter int FLASH_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic flush,
  output logic busy,
  output logic fill_done
);

  localparam int CNT_W = (FLASH_LAT < 2) ? 1 : $clog2(FLASH_LAT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLASH_LAT - 1);

  fb_pkg::refill_state_e state_q;
  logic [CNT_W-1:0]      cnt_q;

  assign busy      = (state_q == fb_pkg::RF_WAIT);
  assign fill_done = busy && (cnt_q == LAST) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= fb_pkg::RF_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        fb_pkg::RF_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= fb_pkg::RF_WAIT;
        end
        fb_pkg::RF_WAIT: begin
          if (flush || (cnt_q == LAST)) begin
            state_q <= fb_pkg::RF_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= fb_pkg::RF_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fb_extract.sv
module fb_extract #(
  parameter int LINE_W = 128,
  parameter int OFF_W  = 4
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  off,
  input  logic              is_word,
  output logic [31:0]       opcode,
  output logic              bad
);

  localparam int NHW = LINE_W / 16;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int IDX_W = $clog2(NHW + 1);

  logic [15:0] hw [0:NHW];

  genvar g;
  generate
    for (g = 0; g < NHW; g++) begin : g_hw
      assign hw[g] = line[g*16 +: 16];
    end
  endgenerate
  assign hw[NHW] = 16'h0000;

  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;

  assign lo_idx = IDX_W'(off >> 1);
  assign hi_idx = lo_idx + 1'b1;

  always_comb begin
    if (is_word) opcode = {hw[hi_idx], hw[lo_idx]};
    else         opcode = {16'h0000, hw[lo_idx]};
  end

  assign bad = fb_pkg::fetch_bad(int'(off), is_word, LINE_BYTES);

endmodule

// File: rtl/fetch_line_buffer.sv
module fetch_line_buffer #(
  parameter int ADDR_W    = 16,
  parameter int LINE_W    = 128,
  parameter int FLASH_LAT = 4,
  localparam int LINE_BYTES = LINE_W / 8,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int TAG_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_word,
  output logic              fetch_ready,
  output logic              fetch_err,
  output logic [31:0]       fetch_opcode,
  output logic              flash_rd,
  output logic [TAG_W-1:0]  flash_addr,
  input  logic [LINE_W-1:0] flash_data
);

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic              refill_busy;
  logic              fill_done;
  logic              bad_fetch;
  logic              hit;
  logic              miss_start;
  logic [TAG_W-1:0]  pend_tag_q;

  assign req_tag = fetch_addr[ADDR_W-1:OFF_W];
  assign req_off = fetch_addr[OFF_W-1:0];

  fb_extract #(.LINE_W(LINE_W), .OFF_W(OFF_W)) u_extract (
    .line    (line_data),
    .off     (req_off),
    .is_word (fetch_word),
    .opcode  (fetch_opcode),
    .bad     (bad_fetch)
  );

  assign hit        = fetch_req && !bad_fetch && line_valid &&
                      (line_tag == req_tag) && !refill_busy;
  assign miss_start = fetch_req && !bad_fetch && !hit && !refill_busy && !flush;

  fb_refill_ctrl #(.FLASH_LAT(FLASH_LAT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (miss_start),
    .flush     (flush),
    .busy      (refill_busy),
    .fill_done (fill_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_tag_q <= '0;
    else if (miss_start) pend_tag_q <= req_tag;
  end

  fb_line_store #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .load      (fill_done),
    .load_tag  (pend_tag_q),
    .load_data (flash_data),
    .valid     (line_valid),
    .tag       (line_tag),
    .data      (line_data)
  );

  assign fetch_ready = hit;
  assign fetch_err   = fetch_req && bad_fetch;
  assign flash_rd    = miss_start;
  assign flash_addr  = req_tag;

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int FLASH_LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic fetch_req,
  input logic fetch_ready,
  input logic fetch_err,
  input logic flash_rd,
  input logic fill_done,
  input logic line_valid
);

  logic [15:0] since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rd <= 16'hFFFF;
    else if (flash_rd)       since_rd <= 16'd1;
    else if (since_rd != 16'hFFFF) since_rd <= since_rd + 16'd1;
  end

  p_ready_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> line_valid);

  p_ready_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_req);

  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> !flash_rd);

  p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rd |=> !flash_rd);

  p_fill_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (since_rd == 16'(FLASH_LAT)));

  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> line_valid);

  p_err_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (!fetch_ready && !flash_rd));

  p_flush_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !line_valid);

endmodule

bind fetch_line_buffer fb_checker #(.FLASH_LAT(FLASH_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .fetch_req   (fetch_req),
  .fetch_ready (fetch_ready),
  .fetch_err   (fetch_err),
  .flash_rd    (flash_rd),
  .fill_done   (fill_done),
  .line_valid  (line_valid)
);

// File: tb/sim_fetch_line_buffer.sv
module sim_fetch_line_buffer;

  localparam int AW  = 12;
  localparam int LW  = 128;
  localparam int LAT = 3;
  localparam int TW  = AW - 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_word = 1'b0;
  logic          fetch_ready, fetch_err, flash_rd;
  logic [31:0]   fetch_opcode;
  logic [TW-1:0] flash_addr;
  logic [LW-1:0] flash_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fetch_line_buffer #(.ADDR_W(AW), .LINE_W(LW), .FLASH_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
    .fetch_err(fetch_err), .fetch_opcode(fetch_opcode), .flash_rd(flash_rd),
    .flash_addr(flash_addr), .flash_data(flash_data)
  );

  // Byte content of the flash at a byte address.
  function automatic logic [7:0] mb(input int a);
    return 8'((a * 29) ^ (a >> 5) ^ 8'h5a);
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [TW-1:0] la);
    logic [LW-1:0] l;
    for (int b = 0; b < LW/8; b++) l[b*8 +: 8] = mb(int'(la) * 16 + b);
    return l;
  endfunction

  function automatic logic [31:0] exp_op(input int a, input logic w);
    if (w) return {mb(a+3), mb(a+2), mb(a+1), mb(a)};
    return {16'h0000, mb(a+1), mb(a)};
  endfunction

  // Flash model: valid data only FLASH_LAT cycles after the read cycle.
  logic [TW-1:0] fa;
  int            age = 1000;
  always_ff @(posedge clk) begin
    if (flash_rd) begin
      fa  <= flash_addr;
      age <= 0;
    end else if (age < 1000) begin
      age <= age + 1;
    end
  end
  assign flash_data = (age == LAT-1) ? line_of(fa) : {4{32'hBAD0_F00D}};

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Issue a fetch at a negedge and follow it until ready or error.
  task automatic fetch(input int a, input logic w, input int exp_cyc,
                       input int exp_rd, input bit exp_err, input string rq);
    int cyc = 0;
    int rds = 0;
    bit got_rdy = 0;
    bit got_err = 0;
    logic [31:0] op = '0;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = AW'(a);
    fetch_word = w;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (flash_rd) begin
        rds++;
        chk(flash_addr == TW'(a >> 4), {rq, " flash_addr"},
            32'(flash_addr), 32'(a >> 4));
      end
      if (fetch_err) begin got_err = 1; break; end
      if (fetch_ready) begin got_rdy = 1; op = fetch_opcode; break; end
      @(negedge clk);
      cyc++;
    end
    chk(got_err == exp_err, {rq, " err"}, 32'(got_err), 32'(exp_err));
    chk(got_rdy == !exp_err, {rq, " ready"}, 32'(got_rdy), 32'(!exp_err));
    chk(cyc == exp_cyc, {rq, " cycles"}, 32'(cyc), 32'(exp_cyc));
    chk(rds == exp_rd, {rq, " reads"}, 32'(rds), 32'(exp_rd));
    if (!exp_err) chk(op == exp_op(a, w), {rq, " opcode"}, op, exp_op(a, w));
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk(!fetch_ready && !fetch_err && !flash_rd, "R1 idle outputs",
        {29'b0, fetch_ready, fetch_err, flash_rd}, 32'h0);
    fetch(12'h040, 1'b1, LAT+1, 1, 0, "R1 R3 R4 first fetch miss");
  endtask

  task automatic t_hits();
    fetch(12'h042, 1'b0, 0, 0, 0, "R2 R5 half hit");
    fetch(12'h04E, 1'b0, 0, 0, 0, "R2 R5 last half hit");
    fetch(12'h04C, 1'b1, 0, 0, 0, "R2 R4 last word hit");
    fetch(12'h044, 1'b1, 0, 0, 0, "R2 R4 word hit");
  endtask

  task automatic t_misalign();
    fetch(12'h046, 1'b1, 0, 0, 1, "R6 word on half boundary");
    fetch(12'h043, 1'b0, 0, 0, 1, "R6 odd half");
    fetch(12'h04F, 1'b0, 0, 0, 1, "R6 half past line end");
    fetch(12'h048, 1'b1, 0, 0, 0, "R6 line kept after error");
  endtask

  task automatic t_replace();
    fetch(12'hFF8, 1'b1, LAT+1, 1, 0, "R9 miss top line");
    fetch(12'hFFE, 1'b0, 0, 0, 0, "R9 hit top line");
    fetch(12'h040, 1'b0, LAT+1, 1, 0, "R9 old line misses");
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    fetch(12'h040, 1'b0, LAT+1, 1, 0, "R7 miss after flush");
  endtask

  task automatic t_flush_mid();
    int cyc = 0;
    int rds = 0;
    bit got = 0;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = 12'h208;
    fetch_word = 1'b1;
    for (int i = 0; i < 40; i++) begin
      flush = (i == 1);
      #1;
      if (flash_rd) rds++;
      if (fetch_ready) begin
        got = 1;
        chk(fetch_opcode == exp_op(12'h208, 1'b1), "R8 opcode after cancel",
            fetch_opcode, exp_op(12'h208, 1'b1));
        break;
      end
      @(negedge clk);
      cyc++;
    end
    flush = 1'b0;
    chk(got, "R8 ready after cancel", 32'(got), 32'd1);
    chk(rds == 2, "R8 reissued read", 32'(rds), 32'd2);
    chk(cyc == LAT+3, "R8 cycles", 32'(cyc), 32'(LAT+3));
    @(negedge clk);
    fetch_req = 1'b0;
    fetch(12'h20A, 1'b0, 0, 0, 0, "R8 R2 hit after refill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hits();
    t_misalign();
    t_replace();
    t_flush();
    t_flush_mid();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule